// File: doc/BRIEF.md
# Pipelined Diagonal-Bank Transpose Buffer

This block sits between the two one-dimensional passes of a separable 2D transform. The first pass delivers each square block as rows, one row per beat, up to 32 coefficients wide. The buffer stores the rows and hands the same block back as columns, one column per beat. Blocks of different sizes may follow each other with no idle cycle between them. A block can be written while an earlier block is still being read.

Storage is a row of SRAM bank models, one per lane. Element (r, c) of a block lives in bank (r + c) mod LANES, at address base + r. A row write and a column read therefore each touch every bank at most once. A circular allocation pointer and a circular release pointer track the free space. A small FIFO of block descriptors holds size code and base address, and tells the reader how to walk each finished block. For 64-point blocks only the 32 low-frequency columns are stored. The rest read back as zero, so the storage holds two such blocks.

The writer FSM has states WR_IDLE and WR_FILL. WR_IDLE goes to WR_FILL when a start-of-block beat is accepted. WR_FILL goes back to WR_IDLE when the last row is accepted, and that same beat pushes the descriptor. The reader FSM has states RD_IDLE, RD_DATA and RD_ZERO. RD_IDLE goes to RD_DATA when it pops a descriptor. RD_DATA goes to RD_ZERO after the last stored column of a 64-point block. RD_DATA or RD_ZERO, on the last beat of a block, goes to RD_DATA if another descriptor is waiting (chained pop) and to RD_IDLE if not.

Top module: `xpose_buf`

## Requirements
- R1: After reset out_valid is 0, and in_ready is 1 both for a beat with in_sob low and for a start-of-block beat of any size, because the buffer is empty.
- R2: in_size is a size code k in 2..6 giving an N×N block with N = 2^k. Row r arrives as N beats in order, with column c on lane c (bits 16c+15:16c) for c < min(N,32). Input lanes at or above min(N,32) are ignored.
- R3: A block with N ≤ 32 is returned as N beats, column 0 first. In the beat for column c, lane j carries element (j, c) for j < N, and lanes j ≥ N are zero.
- R4: A 64-point block has input lanes 0..31 as columns 0..31. It is returned as 128 beats: for each column c, rows 0–31 first and then rows 32–63, on lanes 0–31. Every beat of columns 32..63 is all zero.
- R5: A start-of-block beat sees in_ready low while no block is open and the free space is smaller than N. Free space is 128 rows minus N for each block that has been opened and not yet fully read out. When free space is enough, in_ready stays high.
- R6: Blocks can enter on consecutive cycles. When a later block is complete before the earlier block's last beat, its first column follows on the next cycle with no gap.
- R7: out_eob is 1 on the last beat of each block and 0 on every other beat.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_col and out_eob hold their values.
- R9: A beat with in_sob low while no block is open is accepted and discarded, and produces no output.
- R10: Blocks leave in arrival order. No beat of a block appears before its last row has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| in_valid | input | 1 | input row beat valid |
| in_ready | output | 1 | input beat accepted when high together with in_valid |
| in_sob | input | 1 | beat is row 0 of a new block |
| in_size | input | 3 | block size code (N = 2^code) |
| in_row | input | 512 | 32 lanes of 16-bit row coefficients |
| out_valid | output | 1 | output column beat valid |
| out_ready | input | 1 | consumer accepts the output beat |
| out_col | output | 512 | 32 lanes of 16-bit column coefficients |
| out_eob | output | 1 | last beat of the block |

## Verification
The bench targets the following corner cases:
- **Lane rotation.** Input rows carry junk on their unused lanes. A wrong rotation or wrong masking would then leak nonzero or misplaced values into output lanes.
- **64-point blocks.** These check the two-half column order and the zero-only columns. A reader that read memory for column 32 or more, or swapped halves, would return stale rows.
- **Full buffer.** Two 64-point blocks fill the store while the output is stalled. A third block must then wait, and a design with a wrong free-space formula would overwrite data that has not been read.
- **Pipelining and stray beats.** Back-to-back 32-point blocks expose a reader that idles a cycle between blocks. A stray beat with no block open exposes a writer that would take it as row 0.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

    localparam int SZW = 3;

    typedef enum logic {
        WR_IDLE,
        WR_FILL
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_DATA,
        RD_ZERO
    } rd_state_e;

endpackage

// File: rtl/xpose_bank.sv
module xpose_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xpose_desc_fifo.sv
module xpose_desc_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            if (push && !pop)      cnt <= cnt + (AW+1)'(1);
            else if (pop && !push) cnt <= cnt - (AW+1)'(1);
        end
    end

    // R5: space accounting keeps the descriptor count within the FIFO
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop))
        else $error("descriptor FIFO overflow");

    // R10: the reader only starts blocks that have been completed
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("descriptor FIFO underflow");
endmodule

// File: rtl/xpose_writer.sv
module xpose_writer
    import xpose_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int MAXN  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_sob,
    input  logic [SZW-1:0]                in_size,
    input  logic [LANES*DW-1:0]           in_row,
    output logic                          in_ready,
    input  logic [$clog2(DEPTH):0]        rel_ptr,
    output logic [LANES-1:0]              wr_en,
    output logic [$clog2(DEPTH)-1:0]      wr_addr,
    output logic [LANES*DW-1:0]           wr_data,
    output logic                          push,
    output logic [SZW+$clog2(DEPTH)-1:0]  push_data
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LOG_L = $clog2(LANES);
    localparam int NW    = $clog2(MAXN) + 1;

    function automatic logic [LOG_L:0] lane_width(input logic [SZW-1:0] code);
        if (int'(code) >= LOG_L) return (LOG_L+1)'(LANES);
        else                     return (LOG_L+1)'(1) << code;
    endfunction

    wr_state_e st, st_nx;

    logic [AW:0]      alloc;
    logic [AW-1:0]    base;
    logic [NW-1:0]    row;
    logic [SZW-1:0]   code;

    logic [AW:0]      occ, room, need;
    logic             accept, opening, writing, last_row;
    logic [NW-1:0]    cur_row, cur_n;
    logic [SZW-1:0]   cur_code;
    logic [AW-1:0]    cur_base;
    logic [LOG_L:0]   cur_w;

    // free space: rows not reserved by any open or unread block
    assign occ  = alloc - rel_ptr;
    assign room = (AW+1)'(DEPTH) - occ;
    assign need = (AW+1)'(1) << in_size;

    assign in_ready = (st == WR_FILL) || !in_sob || (room >= need);
    assign accept   = in_valid && in_ready;
    assign opening  = accept && (st == WR_IDLE) && in_sob;
    assign writing  = accept && ((st == WR_FILL) || in_sob);

    assign cur_row  = (st == WR_FILL) ? row  : '0;
    assign cur_code = (st == WR_FILL) ? code : in_size;
    assign cur_base = (st == WR_FILL) ? base : alloc[AW-1:0];
    assign cur_n    = NW'(1) << cur_code;
    assign cur_w    = lane_width(cur_code);
    assign last_row = (st == WR_FILL) && (row == cur_n - NW'(1));

    assign wr_addr   = cur_base + AW'(cur_row);
    assign push      = accept && last_row;
    assign push_data = {code, base};

    // diagonal placement: column c of row r goes to bank (r + c) mod LANES
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LOG_L-1:0] src;
        assign src = LOG_L'(k) - cur_row[LOG_L-1:0];
        assign wr_en[k] = writing && ({1'b0, src} < cur_w);
        assign wr_data[k*DW +: DW] = in_row[src*DW +: DW];
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            WR_IDLE: if (opening)           st_nx = WR_FILL;
            WR_FILL: if (accept && last_row) st_nx = WR_IDLE;
            default:                        st_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WR_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alloc <= '0;
            base  <= '0;
            row   <= '0;
            code  <= '0;
        end else if (opening) begin
            base  <= alloc[AW-1:0];
            code  <= in_size;
            alloc <= alloc + need;
            row   <= NW'(1);
        end else if (accept && (st == WR_FILL)) begin
            row   <= row + NW'(1);
        end
    end

    // R5: reservations never exceed the storage
    assert_room_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (AW+1)'(DEPTH))
        else $error("reserved rows exceed storage");

    // R2: only supported size codes open a block
    assert_size_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        opening |-> (in_size >= SZW'(2) && int'(in_size) <= $clog2(MAXN)))
        else $error("unsupported size code");
endmodule

// File: rtl/xpose_reader.sv
module xpose_reader
    import xpose_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 128,
    parameter int MAXN  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fifo_empty,
    input  logic [SZW+$clog2(DEPTH)-1:0]  fifo_data,
    output logic                          fifo_pop,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic                          out_eob,
    output logic [LANES-1:0]              rd_en,
    output logic [LANES*$clog2(DEPTH)-1:0] rd_addr,
    output logic [$clog2(LANES)-1:0]      m_shift,
    output logic [$clog2(LANES):0]        m_width,
    output logic                          m_zero,
    output logic [$clog2(DEPTH):0]        rel_ptr
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LOG_L = $clog2(LANES);
    localparam int NW    = $clog2(MAXN) + 1;

    function automatic logic [LOG_L:0] lane_width(input logic [SZW-1:0] c);
        if (int'(c) >= LOG_L) return (LOG_L+1)'(LANES);
        else                  return (LOG_L+1)'(1) << c;
    endfunction

    rd_state_e st, st_nx;

    logic [NW-1:0]  col;
    logic           half;
    logic [SZW-1:0] code;
    logic [AW-1:0]  base;

    logic           slot, issue, last, wide, load, data_issue;
    logic [NW-1:0]  n;
    logic [LOG_L:0] w;

    assign slot       = !out_valid || out_ready;
    assign issue      = slot && (st != RD_IDLE);
    assign data_issue = issue && (st == RD_DATA);
    assign n          = NW'(1) << code;
    assign w          = lane_width(code);
    assign wide       = int'(code) > LOG_L;
    assign last       = (col == n - NW'(1)) && (!wide || half);
    assign load       = !fifo_empty && ((st == RD_IDLE) || (issue && last));
    assign fifo_pop   = load;

    // column c, half h: lane j sits in bank (j + c) mod LANES at base + h*LANES + j
    for (genvar k = 0; k < LANES; k++) begin : g_bank
        logic [LOG_L-1:0] j;
        assign j = LOG_L'(k) - col[LOG_L-1:0];
        assign rd_en[k] = data_issue && ({1'b0, j} < w);
        assign rd_addr[k*AW +: AW] = base + (half ? AW'(LANES) : AW'(0)) + AW'(j);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_IDLE: if (load) st_nx = RD_DATA;
            RD_DATA: begin
                if (issue) begin
                    if (last)
                        st_nx = load ? RD_DATA : RD_IDLE;
                    else if (wide && half && col == NW'(LANES - 1))
                        st_nx = RD_ZERO;
                end
            end
            RD_ZERO: if (issue && last) st_nx = load ? RD_DATA : RD_IDLE;
            default: st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col  <= '0;
            half <= 1'b0;
            code <= '0;
            base <= '0;
        end else if (load) begin
            code <= fifo_data[SZW+AW-1:AW];
            base <= fifo_data[AW-1:0];
            col  <= '0;
            half <= 1'b0;
        end else if (issue) begin
            if (wide) begin
                half <= !half;
                if (half) col <= col + NW'(1);
            end else begin
                col <= col + NW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_ptr   <= '0;
            out_valid <= 1'b0;
            out_eob   <= 1'b0;
            m_shift   <= '0;
            m_width   <= '0;
            m_zero    <= 1'b0;
        end else begin
            if (issue && last) rel_ptr <= rel_ptr + (AW+1)'(n);
            if (issue) begin
                out_valid <= 1'b1;
                out_eob   <= last;
                m_shift   <= col[LOG_L-1:0];
                m_width   <= w;
                m_zero    <= (st == RD_ZERO);
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R4: zero-only columns exist only for blocks wider than the lanes
    assert_zero_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RD_ZERO) |-> wide)
        else $error("zero columns on a narrow block");

    // R7: a new block starts only right after an end-of-block beat or from idle
    assert_eob_before_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st != RD_IDLE) |=> out_eob)
        else $error("block switch without end-of-block beat");
endmodule

// File: rtl/xpose_buf.sv
module xpose_buf
    import xpose_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int MAXN  = 64,
    parameter int MINN  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sob,
    input  logic [SZW-1:0]       in_size,
    input  logic [LANES*DW-1:0]  in_row,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [LANES*DW-1:0]  out_col,
    output logic                 out_eob
);
    localparam int AW         = $clog2(DEPTH);
    localparam int LOG_L      = $clog2(LANES);
    localparam int DESC_W     = SZW + AW;
    localparam int DESC_DEPTH = DEPTH / MINN;

    logic [LANES-1:0]      wr_en, rd_en;
    logic [AW-1:0]         wr_addr;
    logic [LANES*AW-1:0]   rd_addr;
    logic [LANES*DW-1:0]   wr_data, bank_q;
    logic                  push, pop, fifo_empty, fifo_full;
    logic [DESC_W-1:0]     push_data, fifo_data;
    logic [AW:0]           rel_ptr;
    logic [LOG_L-1:0]      m_shift;
    logic [LOG_L:0]        m_width;
    logic                  m_zero;

    xpose_writer #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH), .MAXN(MAXN)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sob(in_sob), .in_size(in_size), .in_row(in_row),
        .in_ready(in_ready), .rel_ptr(rel_ptr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .push(push), .push_data(push_data)
    );

    xpose_desc_fifo #(.W(DESC_W), .DEPTH(DESC_DEPTH)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(push_data), .pop(pop), .dout(fifo_data),
        .empty(fifo_empty), .full(fifo_full)
    );

    xpose_reader #(.LANES(LANES), .DEPTH(DEPTH), .MAXN(MAXN)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(pop),
        .out_ready(out_ready), .out_valid(out_valid), .out_eob(out_eob),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .m_shift(m_shift), .m_width(m_width), .m_zero(m_zero),
        .rel_ptr(rel_ptr)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        xpose_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(wr_en[k]), .waddr(wr_addr), .wdata(wr_data[k*DW +: DW]),
            .re(rd_en[k]), .raddr(rd_addr[k*AW +: AW]),
            .rdata(bank_q[k*DW +: DW])
        );

        // R10: the block being filled never shares an address with one being drained
        assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[k] && rd_en[k]) |-> (wr_addr != rd_addr[k*AW +: AW]))
            else $error("write and read collide in a bank");
    end

    // undo the diagonal: lane j of column c comes from bank (j + c) mod LANES
    for (genvar j = 0; j < LANES; j++) begin : g_out
        logic [LOG_L-1:0] pick;
        assign pick = LOG_L'(j) + m_shift;
        assign out_col[j*DW +: DW] =
            (!m_zero && ((LOG_L+1)'(j) < m_width)) ? bank_q[pick*DW +: DW] : '0;
    end

    // R8: a stalled beat is held unchanged
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_eob)))
        else $error("output changed under back-pressure");
endmodule

// File: tb/tb_xpose_buf.sv
module tb_xpose_buf;
    localparam int LANES = 32;
    localparam int DW    = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                rst_n;
    logic                in_valid, in_ready, in_sob;
    logic [2:0]          in_size;
    logic [LANES*DW-1:0] in_row;
    logic                out_valid, out_ready, out_eob;
    logic [LANES*DW-1:0] out_col;

    xpose_buf dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sob(in_sob),
        .in_size(in_size), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_col(out_col), .out_eob(out_eob)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int in_gap_pct = 0;
    int out_stall_pct = 0;
    bit gap_watch = 0;
    bit started = 0;
    int gap_cnt = 0;
    int tag_next = 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LANES*DW-1:0] act, input logic [LANES*DW-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] elem(input int tag, input int r, input int c);
        return {4'(tag), 6'(r), 6'(c)};
    endfunction

    function automatic logic [LANES*DW-1:0] row_vec(input int tag, input int n, input int r);
        logic [LANES*DW-1:0] v;
        int w;
        w = (n < LANES) ? n : LANES;
        for (int c = 0; c < LANES; c++)
            v[c*DW +: DW] = (c < w) ? elem(tag, r, c) : (16'hA5A5 ^ 16'(c));
        return v;
    endfunction

    function automatic logic [LANES*DW-1:0] exp_vec(input int tag, input int n,
                                                   input int c, input int h);
        logic [LANES*DW-1:0] v;
        bit ok;
        for (int j = 0; j < LANES; j++) begin
            ok = (n <= LANES) ? (j < n) : (c < LANES);
            v[j*DW +: DW] = ok ? elem(tag, h*LANES + j, c) : 16'h0;
        end
        return v;
    endfunction

    function automatic logic [2:0] code_of(input int n);
        return 3'($clog2(n));
    endfunction

    task automatic drive_beat(input logic [LANES*DW-1:0] v, input bit sob, input logic [2:0] code);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            if ($urandom_range(0, 99) < in_gap_pct) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_sob   = sob;
                in_size  = code;
                in_row   = v;
                #4;
                if (in_ready) begin
                    @(posedge clk);
                    done = 1;
                end
            end
        end
    endtask

    task automatic in_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sob   = 1'b0;
    endtask

    task automatic send_block(input int tag, input int n);
        for (int r = 0; r < n; r++)
            drive_beat(row_vec(tag, n, r), (r == 0), code_of(n));
    endtask

    task automatic wait_beat(output logic [LANES*DW-1:0] v, output logic e);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            out_ready = ($urandom_range(0, 99) >= out_stall_pct);
            #4;
            if (out_valid && out_ready) begin
                v = out_col;
                e = out_eob;
                started = 1;
                @(posedge clk);
                done = 1;
            end else if (gap_watch && started && out_ready && !out_valid) begin
                gap_cnt = gap_cnt + 1;
            end
        end
    endtask

    task automatic recv_block(input int tag, input int n);
        int beats;
        logic [LANES*DW-1:0] v;
        logic e;
        string req;
        beats = (n <= LANES) ? n : 2 * n;
        req   = (n <= LANES) ? "R3" : "R4";
        for (int b = 0; b < beats; b++) begin
            int c, h;
            c = (n <= LANES) ? b : b / 2;
            h = (n <= LANES) ? 0 : b % 2;
            wait_beat(v, e);
            chk(v == exp_vec(tag, n, c, h), req, $sformatf("n=%0d col=%0d half=%0d", n, c, h),
                v, exp_vec(tag, n, c, h));
            chk(e == (b == beats - 1), "R7", $sformatf("eob n=%0d beat=%0d", n, b),
                {{(LANES*DW-1){1'b0}}, e}, {{(LANES*DW-1){1'b0}}, (b == beats - 1)});
        end
    endtask

    task automatic run_stream(input int sizes[]);
        int base_tag;
        base_tag = tag_next;
        tag_next = tag_next + sizes.size();
        fork
            begin
                foreach (sizes[i]) send_block((base_tag + i) % 16, sizes[i]);
                in_idle();
            end
            begin
                foreach (sizes[i]) recv_block((base_tag + i) % 16, sizes[i]);
            end
        join
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_sob = 1'b0; in_size = 3'd2;
        in_row = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", {511'b0, out_valid}, '0);
        chk(in_ready == 1'b1, "R1", "in_ready idle", {511'b0, in_ready}, 512'b1);
        in_sob = 1'b1; in_size = 3'd6;
        #0.5;
        chk(in_ready == 1'b1, "R1", "in_ready sob size64", {511'b0, in_ready}, 512'b1);
        in_sob = 1'b0;
    endtask

    // R2 R3 R7 R10: each narrow size alone; no output before the last row
    task automatic t_single_sizes();
        int early;
        bit sending;
        out_stall_pct = 0; in_gap_pct = 0;
        for (int k = 2; k <= 5; k++) begin
            int n, tag;
            n = 1 << k;
            tag = tag_next % 16;
            tag_next++;
            early = 0;
            sending = 1;
            @(negedge clk) out_ready = 1'b1;
            fork
                begin send_block(tag, n); sending = 0; in_idle(); end
                begin
                    while (sending) begin
                        @(negedge clk); #4;
                        if (out_valid && sending) early++;
                    end
                end
            join
            chk(early == 0, "R10", $sformatf("output before last row n=%0d", n),
                512'(early), '0);
            recv_block(tag, n);
        end
    endtask

    task automatic t_wide();
        out_stall_pct = 30; in_gap_pct = 20;
        run_stream('{64});
    endtask

    task automatic t_mixed();
        int sz[];
        sz = new[12];
        foreach (sz[i]) sz[i] = 1 << $urandom_range(2, 6);
        sz[3] = 64; sz[4] = 4;
        out_stall_pct = 40; in_gap_pct = 30;
        run_stream(sz);
    endtask

    task automatic t_throughput();
        out_stall_pct = 0; in_gap_pct = 0;
        gap_watch = 1; started = 0; gap_cnt = 0;
        run_stream('{32, 32, 32, 32});
        gap_watch = 0;
        chk(gap_cnt == 0, "R6", "idle cycles between back-to-back blocks",
            512'(gap_cnt), '0);
    endtask

    task automatic t_full();
        int ta, tb, tc, bad_ready, bad_hold;
        logic [LANES*DW-1:0] snap;
        logic snap_eob;
        ta = tag_next % 16; tb = (tag_next + 1) % 16; tc = (tag_next + 2) % 16;
        tag_next = tag_next + 3;
        out_stall_pct = 0; in_gap_pct = 0;
        @(negedge clk) out_ready = 1'b0;
        send_block(ta, 64);
        send_block(tb, 64);
        @(negedge clk);
        in_valid = 1'b1; in_sob = 1'b1; in_size = code_of(4); in_row = row_vec(tc, 4, 0);
        #4;
        snap = out_col; snap_eob = out_eob;
        bad_ready = 0; bad_hold = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #4;
            if (in_ready) bad_ready++;
            if (!out_valid || out_col != snap || out_eob != snap_eob) bad_hold++;
        end
        chk(bad_ready == 0, "R5", "in_ready while storage full", 512'(bad_ready), '0);
        chk(bad_hold == 0, "R8", "beat held while stalled", 512'(bad_hold), '0);
        fork
            begin send_block(tc, 4); in_idle(); end
            begin recv_block(ta, 64); recv_block(tb, 64); recv_block(tc, 4); end
        join
    endtask

    task automatic t_stray();
        int extra;
        int tag;
        tag = tag_next % 16;
        tag_next++;
        out_stall_pct = 0; in_gap_pct = 0;
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_sob = 1'b0; in_size = code_of(8); in_row = row_vec(15, 8, 0);
        #4;
        chk(in_ready == 1'b1, "R9", "stray beat accepted", {511'b0, in_ready}, 512'b1);
        @(posedge clk);
        fork
            begin send_block(tag, 4); in_idle(); end
            recv_block(tag, 4);
        join
        extra = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #4;
            if (out_valid) extra++;
        end
        chk(extra == 0, "R9", "no output from stray beat", 512'(extra), '0);
    endtask

    initial begin
        t_reset();
        t_single_sizes();
        t_wide();
        t_mixed();
        t_throughput();
        t_full();
        t_stray();
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule